// File: doc/BRIEF.md
# Debug Channel Access Trap Decoder

This block is a purely combinational decoder. It sits beside the instruction decode path and decides whether a user-level access to one of the debug communication channel registers must be diverted to a trap handler. A trap is raised only when the trap enable is set and the access comes from the user privilege level. In that case the decision depends on the instruction-set state, the kind of access instruction, the register it names and whether the core is currently in debug state.

When a trap is raised, the block also reports a 6-bit syndrome class that depends on the access kind. It reports the handler level as well: the hypervisor level when that level exists, is enabled and its general routing flag is set, and the kernel level otherwise. The access itself is performed elsewhere. This block only produces the decision and its side information in the same cycle.

Encodings used throughout: `priv_lvl` 0 is user, 1 kernel, 2 hypervisor, 3 monitor. `acc_kind` 0 is a system-register move, 1 a coprocessor single move, 2 a coprocessor double move, 3 a coprocessor load/store. `reg_id` 0 is the 64-bit channel status register and 1, 2, 3 are the 64-bit data-transfer registers (combined, transmit, receive). 4 is the 32-bit internal status register, 5 the ID register, 6 and 7 the two address registers, 8 the 32-bit internal receive register and 9 the 32-bit internal transmit register. Values 10 to 15 are unused.

Top module: `dcc_trap_decoder`

## Requirements
- R1: When `trap_en` is 0, or `priv_lvl` is not 0 (user), `trap` is 0 whatever the other inputs are.
- R2: In 64-bit state (`a64_state`=1), a system-register move (`acc_kind`=0) to the channel status register (`reg_id`=0) traps with syndrome 0x18, in or out of debug state.
- R3: In 64-bit state, a system-register move to `reg_id` 1, 2 or 3 traps with syndrome 0x18 only when `in_debug` is 0. With `in_debug`=1 it does not trap.
- R4: In 32-bit state (`a64_state`=0), a coprocessor single move (`acc_kind`=1) traps with syndrome 0x05 for `reg_id` 4 to 7 always, and for `reg_id` 8 or 9 only when `in_debug` is 0.
- R5: In 32-bit state, a coprocessor load/store (`acc_kind`=3) traps with syndrome 0x06 when it loads (`mem_load`=1) into `reg_id` 8, or stores (`mem_load`=0) from `reg_id` 9. Debug state does not affect this case.
- R6: In 32-bit state, a coprocessor double move (`acc_kind`=2) traps with syndrome 0x0C for `reg_id` 6 or 7.
- R7: A raised trap reports `target_lvl`=2 when `hyp_present`, `hyp_enabled` and `hyp_route` are all 1, and `target_lvl`=1 otherwise.
- R8: Any state/kind/register combination not listed in R2 to R6 does not trap. This includes the unused `reg_id` values 10 to 15, access kinds 1 to 3 in 64-bit state and kind 0 in 32-bit state. When `trap` is 0, `syndrome` and `target_lvl` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_lvl | input | 2 | Current privilege level (0 user, 1 kernel, 2 hypervisor, 3 monitor) |
| a64_state | input | 1 | 1 for 64-bit instruction-set state, 0 for 32-bit |
| acc_kind | input | 2 | Access instruction kind (0 sysreg move, 1 coproc move, 2 coproc double move, 3 coproc load/store) |
| reg_id | input | 4 | Identifier of the register accessed |
| mem_load | input | 1 | For load/store kind: 1 load into the register, 0 store from it |
| in_debug | input | 1 | Core is in debug state |
| trap_en | input | 1 | User-level channel trap enable |
| hyp_present | input | 1 | Hypervisor level is implemented |
| hyp_enabled | input | 1 | Hypervisor level is enabled for the current security state |
| hyp_route | input | 1 | Hypervisor general-trap routing flag |
| trap | output | 1 | Access must be trapped |
| target_lvl | output | 2 | Level that takes the trap (1 or 2), 0 when no trap |
| syndrome | output | 6 | Syndrome class of the trap, 0 when no trap |

## Verification
The assertions watch every input change. They check that no trap ever leaves a disabled or non-user context, that an idle trap output carries a zero syndrome and level, and that each raised trap carries the syndrome matching its access kind and the routing-correct level. The debug-state exemption of the 64-bit data-transfer registers is checked the same way. The exact set of registers that trap for each kind, the load versus store asymmetry and the silence on unused identifiers are only shown by the bench, which sweeps directed corners and a long random mix against its own model.

// File: rtl/dcc_trap_pkg.sv
package dcc_trap_pkg;

  localparam int LVL_W = 2;
  localparam int KIND_W = 2;
  localparam int REG_W = 4;
  localparam int SYN_W = 6;

  typedef enum logic [LVL_W-1:0] {
    LVL_USER = 2'd0,
    LVL_KERN = 2'd1,
    LVL_HYP  = 2'd2,
    LVL_MON  = 2'd3
  } lvl_e;

  typedef enum logic [KIND_W-1:0] {
    KIND_SYSMOVE = 2'd0,
    KIND_CPMOVE  = 2'd1,
    KIND_CPDBL   = 2'd2,
    KIND_CPLDST  = 2'd3
  } kind_e;

  // Register identifiers
  localparam logic [REG_W-1:0] RID_STAT64  = 4'd0;
  localparam logic [REG_W-1:0] RID_DTR64   = 4'd1;
  localparam logic [REG_W-1:0] RID_DTRTX64 = 4'd2;
  localparam logic [REG_W-1:0] RID_DTRRX64 = 4'd3;
  localparam logic [REG_W-1:0] RID_STAT32  = 4'd4;
  localparam logic [REG_W-1:0] RID_IDENT32 = 4'd5;
  localparam logic [REG_W-1:0] RID_ADDRA32 = 4'd6;
  localparam logic [REG_W-1:0] RID_ADDRB32 = 4'd7;
  localparam logic [REG_W-1:0] RID_RXINT32 = 4'd8;
  localparam logic [REG_W-1:0] RID_TXINT32 = 4'd9;

  // Syndrome classes
  localparam logic [SYN_W-1:0] SYN_SYSREG = 6'h18;
  localparam logic [SYN_W-1:0] SYN_CPMOVE = 6'h05;
  localparam logic [SYN_W-1:0] SYN_CPLDST = 6'h06;
  localparam logic [SYN_W-1:0] SYN_CPDBL  = 6'h0C;

endpackage

// File: rtl/dcc_a64_decode.sv
module dcc_a64_decode
  import dcc_trap_pkg::*;
(
  input  logic [KIND_W-1:0] acc_kind,
  input  logic [REG_W-1:0]  reg_id,
  input  logic              in_debug,
  output logic              hit,
  output logic [SYN_W-1:0]  syn
);

  always_comb begin
    hit = 1'b0;
    if (kind_e'(acc_kind) == KIND_SYSMOVE) begin
      unique case (reg_id)
        RID_STAT64:                          hit = 1'b1;
        RID_DTR64, RID_DTRTX64, RID_DTRRX64: hit = ~in_debug;
        default:                             hit = 1'b0;
      endcase
    end
    syn = hit ? SYN_SYSREG : '0;
  end

endmodule

// File: rtl/dcc_a32_decode.sv
module dcc_a32_decode
  import dcc_trap_pkg::*;
(
  input  logic [KIND_W-1:0] acc_kind,
  input  logic [REG_W-1:0]  reg_id,
  input  logic              mem_load,
  input  logic              in_debug,
  output logic              hit,
  output logic [SYN_W-1:0]  syn
);

  logic hit_move;
  logic hit_dbl;
  logic hit_ldst;

  always_comb begin
    hit_move = 1'b0;
    unique case (reg_id)
      RID_STAT32, RID_IDENT32, RID_ADDRA32, RID_ADDRB32: hit_move = 1'b1;
      RID_RXINT32, RID_TXINT32:                          hit_move = ~in_debug;
      default:                                           hit_move = 1'b0;
    endcase
  end

  always_comb begin
    hit_dbl = (reg_id == RID_ADDRA32) || (reg_id == RID_ADDRB32);
  end

  always_comb begin
    hit_ldst = (mem_load && (reg_id == RID_RXINT32)) ||
               (!mem_load && (reg_id == RID_TXINT32));
  end

  always_comb begin
    hit = 1'b0;
    syn = '0;
    unique case (kind_e'(acc_kind))
      KIND_CPMOVE: begin
        hit = hit_move;
        syn = hit_move ? SYN_CPMOVE : '0;
      end
      KIND_CPDBL: begin
        hit = hit_dbl;
        syn = hit_dbl ? SYN_CPDBL : '0;
      end
      KIND_CPLDST: begin
        hit = hit_ldst;
        syn = hit_ldst ? SYN_CPLDST : '0;
      end
      default: begin
        hit = 1'b0;
        syn = '0;
      end
    endcase
  end

endmodule

// File: rtl/dcc_trap_route.sv
module dcc_trap_route
  import dcc_trap_pkg::*;
(
  input  logic             hyp_present,
  input  logic             hyp_enabled,
  input  logic             hyp_route,
  output logic [LVL_W-1:0] route_lvl
);

  logic to_hyp;

  always_comb begin
    to_hyp    = hyp_present & hyp_enabled & hyp_route;
    route_lvl = to_hyp ? LVL_W'(LVL_HYP) : LVL_W'(LVL_KERN);
  end

endmodule

// File: rtl/dcc_trap_decoder.sv
module dcc_trap_decoder
  import dcc_trap_pkg::*;
(
  input  logic [1:0] priv_lvl,
  input  logic       a64_state,
  input  logic [1:0] acc_kind,
  input  logic [3:0] reg_id,
  input  logic       mem_load,
  input  logic       in_debug,
  input  logic       trap_en,
  input  logic       hyp_present,
  input  logic       hyp_enabled,
  input  logic       hyp_route,
  output logic       trap,
  output logic [1:0] target_lvl,
  output logic [5:0] syndrome
);

  logic             hit64;
  logic [SYN_W-1:0] syn64;
  logic             hit32;
  logic [SYN_W-1:0] syn32;
  logic [LVL_W-1:0] route_lvl;
  logic             user_gate;
  logic             hit_sel;
  logic [SYN_W-1:0] syn_sel;

  dcc_a64_decode u_a64 (
    .acc_kind (acc_kind),
    .reg_id   (reg_id),
    .in_debug (in_debug),
    .hit      (hit64),
    .syn      (syn64)
  );

  dcc_a32_decode u_a32 (
    .acc_kind (acc_kind),
    .reg_id   (reg_id),
    .mem_load (mem_load),
    .in_debug (in_debug),
    .hit      (hit32),
    .syn      (syn32)
  );

  dcc_trap_route u_route (
    .hyp_present (hyp_present),
    .hyp_enabled (hyp_enabled),
    .hyp_route   (hyp_route),
    .route_lvl   (route_lvl)
  );

  always_comb begin
    user_gate  = trap_en && (lvl_e'(priv_lvl) == LVL_USER);
    hit_sel    = a64_state ? hit64 : hit32;
    syn_sel    = a64_state ? syn64 : syn32;
    trap       = user_gate && hit_sel;
    syndrome   = trap ? syn_sel : '0;
    target_lvl = trap ? route_lvl : '0;
  end

endmodule

// File: rtl/dcc_trap_checker.sv
module dcc_trap_checker (
  input logic [1:0] priv_lvl,
  input logic       a64_state,
  input logic [1:0] acc_kind,
  input logic [3:0] reg_id,
  input logic       in_debug,
  input logic       trap_en,
  input logic       hyp_present,
  input logic       hyp_enabled,
  input logic       hyp_route,
  input logic       trap,
  input logic [1:0] target_lvl,
  input logic [5:0] syndrome
);

  always_comb begin
    // R1
    a_r1_gate_off_no_trap: assert (!(!trap_en || priv_lvl != 2'd0) || !trap)
      else $error("R1 trap raised outside enabled user level");
    // R8
    a_r8_idle_outputs_zero: assert (trap || (syndrome == 6'd0 && target_lvl == 2'd0))
      else $error("R8 idle outputs not zero");
    // R7
    a_r7_route_level: assert (!trap ||
        target_lvl == ((hyp_present && hyp_enabled && hyp_route) ? 2'd2 : 2'd1))
      else $error("R7 wrong target level");
    // R2
    a_r2_a64_syndrome: assert (!(trap && a64_state) || syndrome == 6'h18)
      else $error("R2 wrong 64-bit syndrome");
    // R3
    a_r3_debug_exempt: assert (!(a64_state && in_debug && reg_id >= 4'd1 && reg_id <= 4'd3) || !trap)
      else $error("R3 data register trapped in debug state");
    // R4
    a_r4_move_syndrome: assert (!(trap && !a64_state && acc_kind == 2'd1) || syndrome == 6'h05)
      else $error("R4 wrong move syndrome");
    // R5
    a_r5_ldst_syndrome: assert (!(trap && !a64_state && acc_kind == 2'd3) || syndrome == 6'h06)
      else $error("R5 wrong load/store syndrome");
    // R6
    a_r6_dbl_syndrome: assert (!(trap && !a64_state && acc_kind == 2'd2) || syndrome == 6'h0C)
      else $error("R6 wrong double move syndrome");
  end

endmodule

bind dcc_trap_decoder dcc_trap_checker u_checker (
  .priv_lvl    (priv_lvl),
  .a64_state   (a64_state),
  .acc_kind    (acc_kind),
  .reg_id      (reg_id),
  .in_debug    (in_debug),
  .trap_en     (trap_en),
  .hyp_present (hyp_present),
  .hyp_enabled (hyp_enabled),
  .hyp_route   (hyp_route),
  .trap        (trap),
  .target_lvl  (target_lvl),
  .syndrome    (syndrome)
);

// File: tb/dcc_trap_decoder_tb.sv
module dcc_trap_decoder_tb;

  logic       clk;
  logic       rst_n;
  logic [1:0] priv_lvl;
  logic       a64_state;
  logic [1:0] acc_kind;
  logic [3:0] reg_id;
  logic       mem_load;
  logic       in_debug;
  logic       trap_en;
  logic       hyp_present;
  logic       hyp_enabled;
  logic       hyp_route;
  logic       trap;
  logic [1:0] target_lvl;
  logic [5:0] syndrome;

  int n_checks;
  int n_errors;
  bit done;

  dcc_trap_decoder u_dut (
    .priv_lvl    (priv_lvl),
    .a64_state   (a64_state),
    .acc_kind    (acc_kind),
    .reg_id      (reg_id),
    .mem_load    (mem_load),
    .in_debug    (in_debug),
    .trap_en     (trap_en),
    .hyp_present (hyp_present),
    .hyp_enabled (hyp_enabled),
    .hyp_route   (hyp_route),
    .trap        (trap),
    .target_lvl  (target_lvl),
    .syndrome    (syndrome)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model: returns {trap, target_lvl, syndrome}
  function automatic logic [8:0] model(
    input logic [1:0] pl, input logic a64, input logic [1:0] k,
    input logic [3:0] r, input logic ld, input logic dbg, input logic en,
    input logic hp, input logic he, input logic hr);
    logic       t;
    logic [5:0] s;
    logic [1:0] lv;
    t = 1'b0;
    s = 6'd0;
    if (en && pl == 2'd0) begin
      if (a64) begin
        if (k == 2'd0 && r == 4'd0) begin t = 1'b1; s = 6'h18; end
        if (k == 2'd0 && r >= 4'd1 && r <= 4'd3 && !dbg) begin t = 1'b1; s = 6'h18; end
      end else begin
        if (k == 2'd1 && r >= 4'd4 && r <= 4'd7) begin t = 1'b1; s = 6'h05; end
        if (k == 2'd1 && (r == 4'd8 || r == 4'd9) && !dbg) begin t = 1'b1; s = 6'h05; end
        if (k == 2'd3 && ((ld && r == 4'd8) || (!ld && r == 4'd9))) begin t = 1'b1; s = 6'h06; end
        if (k == 2'd2 && (r == 4'd6 || r == 4'd7)) begin t = 1'b1; s = 6'h0C; end
      end
    end
    lv = t ? ((hp && he && hr) ? 2'd2 : 2'd1) : 2'd0;
    return {t, lv, s};
  endfunction

  task automatic drive(input logic [1:0] pl, input logic a64, input logic [1:0] k,
                       input logic [3:0] r, input logic ld, input logic dbg, input logic en,
                       input logic hp, input logic he, input logic hr);
    @(posedge clk);
    #2;
    priv_lvl = pl; a64_state = a64; acc_kind = k; reg_id = r; mem_load = ld;
    in_debug = dbg; trap_en = en; hyp_present = hp; hyp_enabled = he; hyp_route = hr;
    #6;
  endtask

  task automatic check(input string tag);
    logic [8:0] exp;
    exp = model(priv_lvl, a64_state, acc_kind, reg_id, mem_load, in_debug,
                trap_en, hyp_present, hyp_enabled, hyp_route);
    n_checks++;
    if ({trap, target_lvl, syndrome} !== exp) begin
      n_errors++;
      $display("FAIL %s: in pl=%0d a64=%0b k=%0d r=%0d ld=%0b dbg=%0b en=%0b hyp=%0b%0b%0b actual trap=%0b lvl=%0d syn=0x%02h expected trap=%0b lvl=%0d syn=0x%02h",
               tag, priv_lvl, a64_state, acc_kind, reg_id, mem_load, in_debug, trap_en,
               hyp_present, hyp_enabled, hyp_route, trap, target_lvl, syndrome,
               exp[8], exp[7:6], exp[5:0]);
    end
  endtask

  task automatic dcheck(input string tag, input logic [1:0] pl, input logic a64,
                        input logic [1:0] k, input logic [3:0] r, input logic ld,
                        input logic dbg, input logic en, input logic hp,
                        input logic he, input logic hr);
    drive(pl, a64, k, r, ld, dbg, en, hp, he, hr);
    check(tag);
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    priv_lvl = 2'd0; a64_state = 1'b0; acc_kind = 2'd0; reg_id = 4'd0; mem_load = 1'b0;
    in_debug = 1'b0; trap_en = 1'b0; hyp_present = 1'b0; hyp_enabled = 1'b0; hyp_route = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check("R8 reset idle");
    rst_n = 1'b1;

    // R1: enable off, or non-user level
    dcheck("R1 enable off", 2'd0, 1'b1, 2'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int lv = 1; lv < 4; lv++)
      dcheck("R1 kernel/hyp/mon level", 2'(lv), 1'b1, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    dcheck("R1 level 1 in 32-bit", 2'd1, 1'b0, 2'd1, 4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R2: status register in both debug states
    dcheck("R2 status", 2'd0, 1'b1, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    dcheck("R2 status in debug", 2'd0, 1'b1, 2'd0, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    // R3: data-transfer registers exempt in debug
    for (int r = 1; r <= 3; r++) begin
      dcheck("R3 data reg normal", 2'd0, 1'b1, 2'd0, 4'(r), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      dcheck("R3 data reg debug", 2'd0, 1'b1, 2'd0, 4'(r), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    end

    // R4: coprocessor single moves
    for (int r = 4; r <= 9; r++) begin
      dcheck("R4 move normal", 2'd0, 1'b0, 2'd1, 4'(r), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      dcheck("R4 move debug", 2'd0, 1'b0, 2'd1, 4'(r), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    end

    // R5: load/store asymmetry
    dcheck("R5 load rx", 2'd0, 1'b0, 2'd3, 4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    dcheck("R5 store tx", 2'd0, 1'b0, 2'd3, 4'd9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    dcheck("R5 store rx none", 2'd0, 1'b0, 2'd3, 4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    dcheck("R5 load tx none", 2'd0, 1'b0, 2'd3, 4'd9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R6: double moves
    dcheck("R6 addr A", 2'd0, 1'b0, 2'd2, 4'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    dcheck("R6 addr B", 2'd0, 1'b0, 2'd2, 4'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    dcheck("R6 status none", 2'd0, 1'b0, 2'd2, 4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R7: routing combinations
    for (int h = 0; h < 8; h++)
      dcheck("R7 routing", 2'd0, 1'b1, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, h[2], h[1], h[0]);

    // R8: unlisted combinations
    for (int r = 10; r < 16; r++)
      dcheck("R8 unused id", 2'd0, 1'b0, 2'd1, 4'(r), 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    dcheck("R8 a64 coproc kind", 2'd0, 1'b1, 2'd1, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    dcheck("R8 a32 sysmove", 2'd0, 1'b0, 2'd0, 4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    dcheck("R8 a32 on 64-bit id", 2'd0, 1'b0, 2'd1, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // Random mix, biased toward enabled user level
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] v;
      v = $urandom;
      dcheck("R1-R8 random", (v[3:2] == 2'd3) ? v[1:0] : 2'd0, v[4], v[6:5], v[10:7],
             v[11], v[12], v[15:13] != 3'd0, v[16], v[17], v[18]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule